// File: doc/BRIEF.md
# Two-Wire Start/Stop Detector with SCL Wait-State Hold

This block is the bus-condition and clock-stretch part of a serial interface running in two-wire mode. It samples the open-drain SDA and SCL pad levels through synchronisers and recognises two bus conditions. A start is SDA going low while SCL stays high. A stop is SDA going high while SCL stays high. Each condition sets its own sticky flag. The start flag can also raise an interrupt request.

The block stretches the bus clock by pulling SCL low, which gives software time to act. It does this in two cases. After a start, it waits for the master's next SCL falling edge and then holds the line low. When the companion bit counter reports an overflow, it holds the line low at once. A hold lasts until software clears the matching flag by writing a one to it. The line is let go in the same cycle as the clear strobe.

The shift register and the bit counter are outside this block; only the counter's overflow pulse comes in. The block never drives a line high. SCL is only ever released or pulled low through a drive-low enable. A mode input switches the whole two-wire function on or off.

Top module: `twi_wait_ctrl`

## Requirements
- R1: After reset, `start_flag`, `stop_flag`, `ovf_flag`, `start_irq` and `scl_drive_low` are all 0.
- R2: With `mode_en`=1, a change of `sda_in` from 1 to 0 while `scl_in` stays 1 sets `start_flag` on the third rising clock edge after the input change (2 synchroniser stages plus one edge stage). No other change of the two lines sets it, including SDA and SCL falling in the same cycle.
- R3: With `mode_en`=1, a change of `sda_in` from 0 to 1 while `scl_in` stays 1 sets `stop_flag`. No other change of the two lines sets it. A stop never causes `scl_drive_low`.
- R4: After a start, `scl_drive_low` stays 0 while SCL remains high. It goes to 1 on the third rising clock edge after the first falling edge of `scl_in`.
- R5: A start hold persists for as long as SCL would otherwise rise. A 1 on `clr_start` clears `start_flag`, and it drops `scl_drive_low` in the same cycle without waiting for a clock edge.
- R6: With `mode_en`=1, a 1 on `ovf_pulse` sets `ovf_flag` and `scl_drive_low` on the next rising edge. A 1 on `clr_ovf` clears the flag and drops `scl_drive_low` in the same cycle.
- R7: A stop seen after a start but before the next SCL falling edge cancels the pending start hold. That SCL fall then causes no hold, and `start_flag` stays set.
- R8: `start_irq` is 1 exactly when both `start_flag` and `start_ie` are 1. It follows a change of `start_ie` in the same cycle.
- R9: With `mode_en`=0, `scl_drive_low` is 0 and bus conditions or overflow pulses set no flag. Dropping `mode_en` during a hold releases SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en | input | 1 | Two-wire operation enable |
| sda_in | input | 1 | SDA pad level |
| scl_in | input | 1 | SCL pad level |
| ovf_pulse | input | 1 | One-cycle overflow from the bit counter |
| start_ie | input | 1 | Start interrupt enable |
| clr_start | input | 1 | Write-one strobe clearing the start flag and its hold |
| clr_stop | input | 1 | Write-one strobe clearing the stop flag |
| clr_ovf | input | 1 | Write-one strobe clearing the overflow flag and its hold |
| scl_drive_low | output | 1 | Open-drain enable pulling SCL low |
| start_flag | output | 1 | Start condition seen |
| stop_flag | output | 1 | Stop condition seen |
| ovf_flag | output | 1 | Counter overflow seen |
| start_irq | output | 1 | Start interrupt request |

## Verification
Some properties are checked by assertions on every cycle. SCL is never held without a flag behind it. Nothing is held while the mode is off. An overflow always sets its flag. A start hold only begins on an SCL fall that follows a pending start, and it lasts until it is cleared. The bench covers what depends on sequences of pad levels. It sweeps every pair of SDA/SCL states with the mode on and off. It measures the synchroniser latency and the moment the start hold begins. It also covers the stop that cancels a pending hold, and the same-cycle release on a clear.

// File: rtl/twi_pkg.sv
// Package: shared types for the two-wire wait-state controller.
// Assumes: nothing beyond standard SystemVerilog.
package twi_pkg;

    // Bus events decoded from the synchronised lines, one cycle wide each.
    typedef struct packed {
        logic start;     // SDA fell while SCL high
        logic stop;      // SDA rose while SCL high
        logic scl_fall;  // SCL went from high to low
    } twi_evt_t;

    // Idle level of an open-drain line with its pull-up.
    localparam logic LINE_IDLE = 1'b1;

endpackage

// File: rtl/twi_line_sync.sv
// Module: twi_line_sync
// Brings one asynchronous pad level into the clock domain through a chain of
// STAGES flops. It also keeps the previous synchronised value so that edges
// can be seen. Assumes an idle-high open-drain line, so the reset value is 1.
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    output logic lvl_now,
    output logic lvl_prev
);
    import twi_pkg::*;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Metastability chain: first stage samples the pad.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= LINE_IDLE;
        else        chain_q[0] <= pad_in;
    end

    // Remaining synchroniser stages, one per extra parameter count.
    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= LINE_IDLE;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // Edge-detect stage: remembers last cycle's synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= LINE_IDLE;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign lvl_now  = chain_q[STAGES-1];
    assign lvl_prev = prev_q;

endmodule

// File: rtl/twi_cond_detect.sv
// Module: twi_cond_detect
// Decodes start, stop and SCL-fall events from the synchronised SDA/SCL
// levels. SCL must be high in both the previous and the current cycle for an
// SDA edge to count as a condition. All events are suppressed when the
// two-wire mode is off. Purely combinational.
module twi_cond_detect (
    input  logic              mode_en,
    input  logic              sda_now,
    input  logic              sda_prev,
    input  logic              scl_now,
    input  logic              scl_prev,
    output twi_pkg::twi_evt_t evt
);
    logic scl_steady_high;

    // Event decode: SDA edges under a steady-high SCL, plus SCL falls.
    always_comb begin
        scl_steady_high = scl_now & scl_prev;
        evt.start    = mode_en & scl_steady_high & sda_prev & ~sda_now;
        evt.stop     = mode_en & scl_steady_high & ~sda_prev & sda_now;
        evt.scl_fall = mode_en & scl_prev & ~scl_now;
    end

endmodule

// File: rtl/twi_hold_ctrl.sv
// Module: twi_hold_ctrl
// Keeps the sticky start, stop and overflow flags. It arms a start hold that
// engages on the first SCL fall after a start and produces the SCL drive-low
// enable. Flags are cleared by write-one strobes. A set wins over a clear in
// the same cycle. Holds drop combinationally with their clear strobe.
module twi_hold_ctrl (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  twi_pkg::twi_evt_t evt,
    input  logic              ovf_pulse,
    input  logic              clr_start,
    input  logic              clr_stop,
    input  logic              clr_ovf,
    output logic              start_flag,
    output logic              stop_flag,
    output logic              ovf_flag,
    output logic              scl_hold
);
    logic start_q, stop_q, ovf_q;
    logic pend_q, hold_q;

    // Start flag: set by a start event, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)         start_q <= 1'b0;
        else if (evt.start) start_q <= 1'b1;
        else if (clr_start) start_q <= 1'b0;
    end

    // Stop flag: set by a stop event, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)        stop_q <= 1'b0;
        else if (evt.stop) stop_q <= 1'b1;
        else if (clr_stop) stop_q <= 1'b0;
    end

    // Overflow flag: set by a counter overflow in two-wire mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ovf_q <= 1'b0;
        else if (mode_en && ovf_pulse)  ovf_q <= 1'b1;
        else if (clr_ovf)               ovf_q <= 1'b0;
    end

    // Pending start hold: armed by a start, consumed by the next SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_en)                         pend_q <= 1'b0;
        else if (evt.start)                             pend_q <= 1'b1;
        else if (clr_start || evt.stop || evt.scl_fall) pend_q <= 1'b0;
    end

    // Active start hold: engages on SCL fall, lasts until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_en)            hold_q <= 1'b0;
        else if (clr_start)                hold_q <= 1'b0;
        else if (pend_q && evt.scl_fall)   hold_q <= 1'b1;
    end

    // Drive-low enable: either hold, released in the cycle of its clear.
    always_comb begin
        scl_hold = mode_en & ((hold_q & ~clr_start) | (ovf_q & ~clr_ovf));
    end

    assign start_flag = start_q;
    assign stop_flag  = stop_q;
    assign ovf_flag   = ovf_q;

    // R6: an overflow in two-wire mode always leaves the flag set.
    a_r6_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && ovf_pulse) |=> ovf_q);

    // R4: the start hold only begins on an SCL fall with a start pending.
    a_r4_hold_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_q) |-> $past(pend_q && evt.scl_fall));

    // R5: the start hold persists until cleared while the mode stays on.
    a_r5_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !clr_start && mode_en) |=> hold_q);

    // R7: a stop cancels any pending start hold.
    a_r7_stop_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.stop && !evt.start) |=> !pend_q);

endmodule

// File: rtl/twi_wait_ctrl.sv
// Module: twi_wait_ctrl (top)
// Two-wire start/stop detector with SCL wait-state hold. It synchronises the
// pad levels, decodes bus conditions, and keeps the flags and holds. Assumes
// SCL at or below a sixteenth of clk, so each SCL phase spans several cycles.
module twi_wait_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic sda_in,
    input  logic scl_in,
    input  logic ovf_pulse,
    input  logic start_ie,
    input  logic clr_start,
    input  logic clr_stop,
    input  logic clr_ovf,
    output logic scl_drive_low,
    output logic start_flag,
    output logic stop_flag,
    output logic ovf_flag,
    output logic start_irq
);
    import twi_pkg::*;

    logic     sda_now, sda_prev, scl_now, scl_prev;
    twi_evt_t evt;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(sda_in),
        .lvl_now(sda_now), .lvl_prev(sda_prev)
    );

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(scl_in),
        .lvl_now(scl_now), .lvl_prev(scl_prev)
    );

    twi_cond_detect u_detect (
        .mode_en(mode_en),
        .sda_now(sda_now), .sda_prev(sda_prev),
        .scl_now(scl_now), .scl_prev(scl_prev),
        .evt(evt)
    );

    twi_hold_ctrl u_hold (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .evt(evt),
        .ovf_pulse(ovf_pulse),
        .clr_start(clr_start), .clr_stop(clr_stop), .clr_ovf(clr_ovf),
        .start_flag(start_flag), .stop_flag(stop_flag), .ovf_flag(ovf_flag),
        .scl_hold(scl_drive_low)
    );

    // Interrupt request: start flag gated by its enable.
    always_comb begin
        start_irq = start_flag & start_ie;
    end

    // R9: nothing pulls SCL while two-wire mode is off.
    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |-> !scl_drive_low);

    // R5/R6: SCL is only held with a start or overflow flag behind it.
    a_r5_hold_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |-> (start_flag || ovf_flag));

    // R3: a stop alone never starts a hold in the following cycle.
    a_r3_stop_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.stop && !scl_drive_low && !ovf_flag && !ovf_pulse) |=> !scl_drive_low);

endmodule

// File: tb/twi_wait_ctrl_tb.sv
`timescale 1ns/1ps
module twi_wait_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_en = 1'b0;
    logic sda_m = 1'b1;
    logic scl_m = 1'b1;
    logic ovf_pulse = 1'b0;
    logic start_ie = 1'b0;
    logic clr_start = 1'b0, clr_stop = 1'b0, clr_ovf = 1'b0;
    logic scl_drive_low, start_flag, stop_flag, ovf_flag, start_irq;
    logic scl_line;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Wired-AND bus model: the master's SCL and the block's pull-down.
    assign scl_line = scl_m & ~scl_drive_low;

    twi_wait_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
        .sda_in(sda_m), .scl_in(scl_line),
        .ovf_pulse(ovf_pulse), .start_ie(start_ie),
        .clr_start(clr_start), .clr_stop(clr_stop), .clr_ovf(clr_ovf),
        .scl_drive_low(scl_drive_low), .start_flag(start_flag),
        .stop_flag(stop_flag), .ovf_flag(ovf_flag), .start_irq(start_irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Advance n rising edges, then settle on the falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        clr_start = 1'b1; clr_stop = 1'b1; clr_ovf = 1'b1;
        step(1);
        clr_start = 1'b0; clr_stop = 1'b0; clr_ovf = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        check("R1 start_flag", start_flag, 1'b0);
        check("R1 stop_flag", stop_flag, 1'b0);
        check("R1 ovf_flag", ovf_flag, 1'b0);
        check("R1 start_irq", start_irq, 1'b0);
        check("R1 scl_drive_low", scl_drive_low, 1'b0);

        // R2/R3/R9 sweep: every (from,to) pair of {sda,scl}, mode off and on.
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 4; f++) begin
                for (int t = 0; t < 4; t++) begin
                    mode_en = m[0];
                    sda_m = f[1]; scl_m = f[0];
                    step(6);
                    clear_all();
                    step(2);
                    sda_m = t[1]; scl_m = t[0];
                    step(6);
                    check("R2 start sweep", start_flag, (m == 1 && f == 3 && t == 1));
                    check("R3 stop sweep", stop_flag, (m == 1 && f == 1 && t == 3));
                    check("R3/R9 no hold in sweep", scl_drive_low, 1'b0);
                    clear_all();
                end
            end
        end

        // R2: exact latency of start detection.
        mode_en = 1'b1; sda_m = 1'b1; scl_m = 1'b1;
        step(6); clear_all(); step(2);
        sda_m = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 not before third edge", start_flag, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R2 on third edge", start_flag, 1'b1);

        // R8: interrupt follows the enable.
        start_ie = 1'b1; #1;
        check("R8 irq enabled", start_irq, 1'b1);
        start_ie = 1'b0; #1;
        check("R8 irq disabled", start_irq, 1'b0);
        @(negedge clk);

        // R4: no hold while SCL stays high after the start.
        step(8);
        check("R4 high phase not cut", scl_drive_low, 1'b0);
        scl_m = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R4 hold not before third edge", scl_drive_low, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R4 hold on third edge", scl_drive_low, 1'b1);

        // R5: master releases SCL, hold keeps the line low until clear.
        scl_m = 1'b1;
        step(10);
        check("R5 hold persists", scl_drive_low, 1'b1);
        check("R5 line low", scl_line, 1'b0);
        clr_start = 1'b1; #1;
        check("R5 same-cycle release", scl_drive_low, 1'b0);
        @(negedge clk);
        clr_start = 1'b0;
        step(1);
        check("R5 flag cleared", start_flag, 1'b0);
        check("R5 stays released", scl_drive_low, 1'b0);
        sda_m = 1'b1;
        step(6); clear_all(); step(2);

        // R6: overflow hold and release.
        ovf_pulse = 1'b1; #1;
        check("R6 not yet held", scl_drive_low, 1'b0);
        @(negedge clk);
        ovf_pulse = 1'b0;
        check("R6 flag set", ovf_flag, 1'b1);
        check("R6 hold engaged", scl_drive_low, 1'b1);
        step(5);
        check("R6 hold persists", scl_drive_low, 1'b1);
        clr_ovf = 1'b1; #1;
        check("R6 same-cycle release", scl_drive_low, 1'b0);
        @(negedge clk);
        clr_ovf = 1'b0;
        check("R6 flag cleared", ovf_flag, 1'b0);
        step(2);

        // R7: stop between start and SCL fall cancels the hold.
        sda_m = 1'b0; step(6);
        sda_m = 1'b1; step(6);
        scl_m = 1'b0; step(8);
        check("R7 no hold after stop", scl_drive_low, 1'b0);
        check("R7 start flag kept", start_flag, 1'b1);
        check("R7 stop flag set", stop_flag, 1'b1);
        scl_m = 1'b1; step(6); clear_all(); step(2);

        // R9: mode off ignores conditions and overflow.
        mode_en = 1'b0;
        sda_m = 1'b0; step(6);
        scl_m = 1'b0; step(6);
        check("R9 no start flag", start_flag, 1'b0);
        check("R9 no hold", scl_drive_low, 1'b0);
        ovf_pulse = 1'b1; step(1); ovf_pulse = 1'b0; step(1);
        check("R9 no ovf flag", ovf_flag, 1'b0);
        check("R9 no ovf hold", scl_drive_low, 1'b0);
        scl_m = 1'b1; step(4); sda_m = 1'b1; step(6);

        // R9: dropping mode releases an active overflow hold.
        mode_en = 1'b1; step(2);
        ovf_pulse = 1'b1; step(1); ovf_pulse = 1'b0;
        check("R9 hold before mode drop", scl_drive_low, 1'b1);
        mode_en = 1'b0; #1;
        check("R9 release on mode drop", scl_drive_low, 1'b0);
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule